// File: doc/BRIEF.md
# Region-Based Physical Access Guard

This block keeps a bank of protection regions for a single hart and judges every memory access the hart makes against them. Each region has an address register and an 8-bit configuration field. The field holds separate read, write and execute grants, a 2-bit matching mode and a lock bit. Software programs the regions through a simple register port: one write strobe, a register select and a data word, with reads returned in the same cycle.

The check port takes a byte address, the kind of access (instruction fetch, load or store) and the current privilege level. In the same cycle it returns either allow or a fault. A fault is a request for a synchronous access exception in the core. Regions may overlap, and the lowest-numbered matching region alone decides the result. Machine mode passes freely except where a locked region applies. Supervisor and user modes are denied wherever no region matches.

Top module: `pmp_guard`

## Requirements
- R1: After reset every address register and every configuration register reads as zero.
- R2: Select values 0 to 15 reach the address registers of entries 0 to 15. Each address register holds the byte address shifted right by two, in its low 30 bits, and its upper two bits read as zero. Select values 16 to 19 reach the configuration registers. Byte j of configuration register k belongs to entry 4k+j. Within that byte, bit 0 is read, bit 1 is write, bit 2 is execute, bits 4:3 are the mode and bit 7 is the lock. Bits 6:5 always read as zero.
- R3: An entry whose mode is 0 never matches, whatever its grants.
- R4: Mode 2 matches exactly the 4-byte word whose address the register holds.
- R5: Mode 3 matches an aligned region of 2^(n+3) bytes, where n is the number of trailing one bits in the address register.
- R6: Mode 1 matches word addresses at or above the previous entry's register and strictly below its own register. Entry 0 uses zero as its lower bound.
- R7: A fetch needs the execute grant, a load needs the read grant and a store needs the write grant. Kind is encoded 0 fetch, 1 load, 2 store. An enforced entry that lacks the needed grant raises the fault.
- R8: When several entries match, only the lowest-numbered one decides.
- R9: While an entry's lock bit is set, writes to its configuration byte and to its address register are ignored. Other bytes of the same configuration register are still written.
- R10: Privilege is encoded 0 user, 1 supervisor, 3 machine. In machine mode, an access that matches nothing is allowed, and a match on an unlocked entry is allowed. A match on a locked entry is checked against its grants.
- R11: In user or supervisor mode, an access that matches no entry faults.
- R12: While the check valid input is low, both allow and fault stay low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| csr_we | input | 1 | Register write strobe |
| csr_sel | input | 5 | Register select |
| csr_wdata | input | 32 | Register write data |
| csr_rdata | output | 32 | Register read data, combinational |
| chk_valid | input | 1 | Access to be judged this cycle |
| chk_addr | input | 32 | Access byte address |
| chk_kind | input | 2 | Access kind |
| chk_priv | input | 2 | Current privilege level |
| chk_allow | output | 1 | Access may complete |
| chk_fault | output | 1 | Synchronous access exception request |

## Verification
Two things can land on the same cycle. An address can fall inside two overlapping regions whose grants disagree, and machine mode can hit a region whose lock decides whether the grants apply at all. The bench sets up a narrow read-write region inside a wide region that grants everything. It then fetches once from the overlap and once from the wide region alone, and expects a fault only in the overlap. It also makes machine-mode stores to an unlocked read-only entry, which are allowed, and to a locked read-only entry, which fault, while loads to the locked entry are still allowed.

// File: rtl/pmp_guard_pkg.sv
package pmp_guard_pkg;

   typedef enum logic [1:0] {
      MODE_OFF   = 2'd0,
      MODE_TOR   = 2'd1,
      MODE_NA4   = 2'd2,
      MODE_NAPOT = 2'd3
   } match_mode_e;

   typedef struct packed {
      logic        lock;
      logic [1:0]  rsvd;
      match_mode_e mode;
      logic        x;
      logic        w;
      logic        r;
   } region_cfg_t;

   localparam logic [1:0] KIND_FETCH = 2'd0;
   localparam logic [1:0] KIND_LOAD  = 2'd1;
   localparam logic [1:0] KIND_STORE = 2'd2;

   localparam logic [1:0] PRIV_U = 2'd0;
   localparam logic [1:0] PRIV_S = 2'd1;
   localparam logic [1:0] PRIV_M = 2'd3;

   function automatic region_cfg_t clean_cfg(input logic [7:0] raw);
      region_cfg_t c;
      c      = region_cfg_t'(raw);
      c.rsvd = 2'b00;
      return c;
   endfunction

endpackage

// File: rtl/pmp_regs.sv
module pmp_regs
   import pmp_guard_pkg::*;
#(
   parameter int NUM_ENTRIES = 16,
   parameter int XLEN        = 32,
   parameter int WA_W        = 30,
   parameter int SEL_W       = 5
) (
   input  logic                                clk,
   input  logic                                rst_n,
   input  logic                                csr_we,
   input  logic [SEL_W-1:0]                    csr_sel,
   input  logic [XLEN-1:0]                     csr_wdata,
   output logic [XLEN-1:0]                     csr_rdata,
   output region_cfg_t [NUM_ENTRIES-1:0]       cfg_o,
   output logic [NUM_ENTRIES-1:0][WA_W-1:0]    addr_o
);
   localparam int PER_CFG  = XLEN / 8;
   localparam int CFG_BASE = NUM_ENTRIES;

   region_cfg_t [NUM_ENTRIES-1:0]    cfg_q;
   logic [NUM_ENTRIES-1:0][WA_W-1:0] addr_q;

   for (genvar i = 0; i < NUM_ENTRIES; i++) begin : g_entry
      localparam int CSEL = CFG_BASE + i / PER_CFG;
      localparam int BYTE = i % PER_CFG;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            cfg_q[i] <= '0;
         end else if (csr_we && csr_sel == SEL_W'(CSEL) && !cfg_q[i].lock) begin
            cfg_q[i] <= clean_cfg(csr_wdata[BYTE*8 +: 8]);
         end
      end

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            addr_q[i] <= '0;
         end else if (csr_we && csr_sel == SEL_W'(i) && !cfg_q[i].lock) begin
            addr_q[i] <= csr_wdata[WA_W-1:0];
         end
      end
   end

   always_comb begin
      csr_rdata = '0;
      for (int i = 0; i < NUM_ENTRIES; i++) begin
         if (csr_sel == SEL_W'(i)) begin
            csr_rdata[WA_W-1:0] = addr_q[i];
         end
         if (csr_sel == SEL_W'(CFG_BASE + i / PER_CFG)) begin
            csr_rdata[(i % PER_CFG)*8 +: 8] = cfg_q[i];
         end
      end
   end

   assign cfg_o  = cfg_q;
   assign addr_o = addr_q;

endmodule

// File: rtl/pmp_match.sv
module pmp_match
   import pmp_guard_pkg::*;
#(
   parameter int WA_W = 30
) (
   input  match_mode_e     mode,
   input  logic [WA_W-1:0] this_addr,
   input  logic [WA_W-1:0] prev_addr,
   input  logic [WA_W-1:0] word_addr,
   output logic            hit
);
   logic [WA_W-1:0] span_bits;
   logic [WA_W-1:0] keep_mask;

   always_comb begin
      span_bits = this_addr ^ (this_addr + WA_W'(1));
      keep_mask = ~span_bits;
      unique case (mode)
         MODE_TOR:   hit = (word_addr >= prev_addr) && (word_addr < this_addr);
         MODE_NA4:   hit = (word_addr == this_addr);
         MODE_NAPOT: hit = ((word_addr & keep_mask) == (this_addr & keep_mask));
         default:    hit = 1'b0;
      endcase
   end

endmodule

// File: rtl/pmp_decide.sv
module pmp_decide
   import pmp_guard_pkg::*;
#(
   parameter int NUM_ENTRIES = 16
) (
   input  logic [NUM_ENTRIES-1:0]        hit,
   input  region_cfg_t [NUM_ENTRIES-1:0] cfg,
   input  logic                          valid,
   input  logic [1:0]                    kind,
   input  logic [1:0]                    priv,
   output logic                          allow,
   output logic                          fault
);
   region_cfg_t win_cfg;
   logic        found;
   logic        grant_ok;
   logic        verdict;
   logic        unused_fields;

   always_comb begin
      win_cfg = '0;
      found   = 1'b0;
      for (int i = NUM_ENTRIES - 1; i >= 0; i--) begin
         if (hit[i]) begin
            found   = 1'b1;
            win_cfg = cfg[i];
         end
      end
   end

   always_comb begin
      unique case (kind)
         KIND_FETCH: grant_ok = win_cfg.x;
         KIND_STORE: grant_ok = win_cfg.w;
         default:    grant_ok = win_cfg.r;
      endcase
   end

   always_comb begin
      if (!found) begin
         verdict = (priv == PRIV_M);
      end else if (priv == PRIV_M && !win_cfg.lock) begin
         verdict = 1'b1;
      end else begin
         verdict = grant_ok;
      end
   end

   assign allow         = valid & verdict;
   assign fault         = valid & ~verdict;
   assign unused_fields = ^{win_cfg.rsvd, win_cfg.mode};

endmodule

// File: rtl/pmp_guard.sv
module pmp_guard
   import pmp_guard_pkg::*;
#(
   parameter int NUM_ENTRIES = 16,
   parameter int XLEN        = 32,
   parameter int ADDR_W      = 32,
   parameter int SEL_W       = 5
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              csr_we,
   input  logic [SEL_W-1:0]  csr_sel,
   input  logic [XLEN-1:0]   csr_wdata,
   output logic [XLEN-1:0]   csr_rdata,
   input  logic              chk_valid,
   input  logic [ADDR_W-1:0] chk_addr,
   input  logic [1:0]        chk_kind,
   input  logic [1:0]        chk_priv,
   output logic              chk_allow,
   output logic              chk_fault
);
   localparam int WA_W    = ADDR_W - 2;
   localparam int PER_CFG = XLEN / 8;
   localparam int NUM_CFG = NUM_ENTRIES / PER_CFG;

   if (XLEN % 8 != 0 || XLEN < 8) begin : g_bad_xlen
      $error("XLEN must be a positive multiple of 8");
   end
   if (NUM_ENTRIES % PER_CFG != 0) begin : g_bad_entries
      $error("NUM_ENTRIES must fill whole configuration registers");
   end
   if (WA_W < 1 || WA_W > XLEN) begin : g_bad_addr
      $error("ADDR_W - 2 must lie between 1 and XLEN");
   end
   if ((1 << SEL_W) < NUM_ENTRIES + NUM_CFG) begin : g_bad_sel
      $error("SEL_W too narrow for all registers");
   end

   region_cfg_t [NUM_ENTRIES-1:0]    cfg_q;
   logic [NUM_ENTRIES-1:0][WA_W-1:0] addr_q;
   logic [NUM_ENTRIES-1:0]           hit_vec;
   logic [WA_W-1:0]                  word_addr;
   logic                             unused_low;

   assign word_addr  = chk_addr[ADDR_W-1:2];
   assign unused_low = ^chk_addr[1:0];

   pmp_regs #(
      .NUM_ENTRIES(NUM_ENTRIES),
      .XLEN       (XLEN),
      .WA_W       (WA_W),
      .SEL_W      (SEL_W)
   ) u_regs (
      .clk      (clk),
      .rst_n    (rst_n),
      .csr_we   (csr_we),
      .csr_sel  (csr_sel),
      .csr_wdata(csr_wdata),
      .csr_rdata(csr_rdata),
      .cfg_o    (cfg_q),
      .addr_o   (addr_q)
   );

   for (genvar i = 0; i < NUM_ENTRIES; i++) begin : g_match
      logic [WA_W-1:0] lower;
      if (i == 0) begin : g_first
         assign lower = '0;
      end else begin : g_rest
         assign lower = addr_q[i-1];
      end

      pmp_match #(.WA_W(WA_W)) u_match (
         .mode     (cfg_q[i].mode),
         .this_addr(addr_q[i]),
         .prev_addr(lower),
         .word_addr(word_addr),
         .hit      (hit_vec[i])
      );
   end

   pmp_decide #(.NUM_ENTRIES(NUM_ENTRIES)) u_decide (
      .hit  (hit_vec),
      .cfg  (cfg_q),
      .valid(chk_valid),
      .kind (chk_kind),
      .priv (chk_priv),
      .allow(chk_allow),
      .fault(chk_fault)
   );

endmodule

// File: rtl/pmp_guard_chk.sv
module pmp_guard_chk
   import pmp_guard_pkg::*;
#(
   parameter int NUM_ENTRIES = 16,
   parameter int WA_W        = 30
) (
   input logic                             clk,
   input logic                             rst_n,
   input logic                             chk_valid,
   input logic [1:0]                       chk_priv,
   input logic                             chk_allow,
   input logic                             chk_fault,
   input logic [NUM_ENTRIES-1:0]           hit_vec,
   input region_cfg_t [NUM_ENTRIES-1:0]    cfg_q,
   input logic [NUM_ENTRIES-1:0][WA_W-1:0] addr_q
);

   for (genvar i = 0; i < NUM_ENTRIES; i++) begin : g_ent
      // R9
      locked_cfg_chk: assert property (@(posedge clk) disable iff (!rst_n)
         cfg_q[i].lock |=> $stable(cfg_q[i]));

      // R9
      locked_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
         cfg_q[i].lock |=> $stable(addr_q[i]));

      // R3
      off_nohit_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (cfg_q[i].mode == MODE_OFF) |-> !hit_vec[i]);
   end

   // R11
   lowpriv_miss_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (chk_valid && chk_priv != PRIV_M && hit_vec == '0) |-> chk_fault);

   // R10
   mach_miss_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (chk_valid && chk_priv == PRIV_M && hit_vec == '0) |-> chk_allow);

   // R12
   idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !chk_valid |-> (!chk_fault && !chk_allow));

endmodule

bind pmp_guard pmp_guard_chk #(
   .NUM_ENTRIES(NUM_ENTRIES),
   .WA_W       (WA_W)
) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .chk_valid(chk_valid),
   .chk_priv (chk_priv),
   .chk_allow(chk_allow),
   .chk_fault(chk_fault),
   .hit_vec  (hit_vec),
   .cfg_q    (cfg_q),
   .addr_q   (addr_q)
);

// File: tb/sim_pmp_guard.sv
module sim_pmp_guard;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        csr_we = 1'b0;
   logic [4:0]  csr_sel = '0;
   logic [31:0] csr_wdata = '0;
   logic [31:0] csr_rdata;
   logic        chk_valid = 1'b0;
   logic [31:0] chk_addr = '0;
   logic [1:0]  chk_kind = '0;
   logic [1:0]  chk_priv = '0;
   logic        chk_allow;
   logic        chk_fault;

   always #10 clk = ~clk;

   pmp_guard u0 (
      .clk      (clk),
      .rst_n    (rst_n),
      .csr_we   (csr_we),
      .csr_sel  (csr_sel),
      .csr_wdata(csr_wdata),
      .csr_rdata(csr_rdata),
      .chk_valid(chk_valid),
      .chk_addr (chk_addr),
      .chk_kind (chk_kind),
      .chk_priv (chk_priv),
      .chk_allow(chk_allow),
      .chk_fault(chk_fault)
   );

   typedef struct {
      bit          is_rd;
      logic [31:0] exp_data;
      logic        exp_allow;
      logic        exp_fault;
      string       tag;
   } item_t;

   item_t exp_q[$];
   int    n_cmp = 0;
   int    n_bad = 0;

   localparam logic [1:0] F = 2'd0, L = 2'd1, S = 2'd2;
   localparam logic [1:0] PU = 2'd0, PS = 2'd1, PM = 2'd3;

   task automatic wr(input logic [4:0] sel, input logic [31:0] data);
      @(negedge clk);
      chk_valid = 1'b0;
      csr_we    = 1'b1;
      csr_sel   = sel;
      csr_wdata = data;
      @(negedge clk);
      csr_we    = 1'b0;
   endtask

   task automatic rd(input logic [4:0] sel, input logic [31:0] exp, input string tag);
      item_t it;
      @(negedge clk);
      chk_valid = 1'b0;
      csr_sel   = sel;
      it.is_rd = 1'b1; it.exp_data = exp; it.exp_allow = 1'b0;
      it.exp_fault = 1'b0; it.tag = tag;
      exp_q.push_back(it);
   endtask

   task automatic acc(input logic v, input logic [31:0] a, input logic [1:0] k,
                      input logic [1:0] p, input logic flt, input string tag);
      item_t it;
      @(negedge clk);
      chk_valid = v;
      chk_addr  = a;
      chk_kind  = k;
      chk_priv  = p;
      it.is_rd = 1'b0; it.exp_data = '0;
      it.exp_fault = v & flt; it.exp_allow = v & ~flt; it.tag = tag;
      exp_q.push_back(it);
   endtask

   // monitor: compares one pushed item per cycle, 2 ns after the driving edge
   initial begin
      forever begin
         @(negedge clk);
         #2;
         if (exp_q.size() > 0) begin
            item_t it;
            it = exp_q.pop_front();
            n_cmp++;
            if (it.is_rd) begin
               if (csr_rdata !== it.exp_data) begin
                  n_bad++;
                  $display("FAIL %s: rdata actual=%h expected=%h", it.tag, csr_rdata, it.exp_data);
               end
            end else if (chk_allow !== it.exp_allow || chk_fault !== it.exp_fault) begin
               n_bad++;
               $display("FAIL %s: addr=%h allow/fault actual=%b%b expected=%b%b", it.tag,
                        chk_addr, chk_allow, chk_fault, it.exp_allow, it.exp_fault);
            end
         end
      end
   end

   task automatic finish_run();
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   endtask

   initial begin
      repeat (50000) @(posedge clk);
      n_bad++;
      $display("FAIL R1: watchdog actual=running expected=finished");
      finish_run();
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1 reset state
      rd(5'd0,  32'h0, "R1");
      rd(5'd16, 32'h0, "R1");
      rd(5'd19, 32'h0, "R1");

      // program regions
      wr(5'd0, 32'h0000_0400);
      wr(5'd1, 32'h0000_0807);
      wr(5'd2, 32'h0000_1400);
      wr(5'd3, 32'h0000_1500);
      wr(5'd4, 32'h0000_3000);
      wr(5'd16, 32'h0C00_1B11);
      wr(5'd17, 32'h0000_0007);
      wr(5'd18, 32'h0000_0060);
      wr(5'd5,  32'hFFFF_FFFF);

      // R2 register layout
      rd(5'd16, 32'h0C00_1B11, "R2");
      rd(5'd17, 32'h0000_0007, "R2");
      rd(5'd1,  32'h0000_0807, "R2");
      rd(5'd18, 32'h0000_0000, "R2");
      rd(5'd5,  32'h3FFF_FFFF, "R2");

      // R4 single word
      acc(1, 32'h1000, L, PU, 0, "R4");
      acc(1, 32'h1003, L, PU, 0, "R4");
      acc(1, 32'h1004, L, PU, 1, "R4");
      // R7 grants on word entry (read only)
      acc(1, 32'h1000, S, PU, 1, "R7");
      acc(1, 32'h1000, F, PU, 1, "R7");

      // R5 power of two, 64 bytes at 0x2000
      acc(1, 32'h2000, S, PU, 0, "R5");
      acc(1, 32'h203C, S, PU, 0, "R5");
      acc(1, 32'h2040, L, PU, 1, "R5");
      acc(1, 32'h1FFC, L, PU, 1, "R5");
      acc(1, 32'h2010, F, PS, 1, "R7");

      // R6 range [0x5000,0x5400), execute only
      acc(1, 32'h5000, F, PU, 0, "R6");
      acc(1, 32'h53FC, F, PU, 0, "R6");
      acc(1, 32'h5400, F, PU, 1, "R6");
      acc(1, 32'h4FFC, F, PU, 1, "R6");
      acc(1, 32'h5000, L, PU, 1, "R7");

      // R3 disabled entry with all grants set
      acc(1, 32'hC000, L, PU, 1, "R3");

      // R11 / R10 no match
      acc(1, 32'h9000, L, PS, 1, "R11");
      acc(1, 32'h9000, L, PU, 1, "R11");
      acc(1, 32'h9000, L, PM, 0, "R10");
      acc(1, 32'h1000, S, PM, 0, "R10");

      // R12 idle
      acc(0, 32'h9000, L, PU, 0, "R12");

      // R8 overlap: entry 6 grants all over 0x2000..0x3FFF
      wr(5'd6, 32'h0000_0BFF);
      wr(5'd17, 32'h001F_0007);
      acc(1, 32'h2010, F, PU, 1, "R8");
      acc(1, 32'h2100, F, PU, 0, "R8");

      // R9 / R10 locked read-only word at 0x8000
      wr(5'd7, 32'h0000_2000);
      acc(1, 32'h8000, S, PM, 0, "R10");
      wr(5'd17, 32'h911F_0007);
      acc(1, 32'h8000, S, PM, 1, "R10");
      acc(1, 32'h8000, L, PM, 0, "R10");
      wr(5'd7, 32'h0000_2100);
      rd(5'd7, 32'h0000_2000, "R9");
      wr(5'd17, 32'h0000_0000);
      rd(5'd17, 32'h9100_0000, "R9");
      acc(1, 32'h8000, L, PU, 0, "R9");
      acc(1, 32'h8400, L, PU, 1, "R9");

      @(negedge clk);
      chk_valid = 1'b0;
      repeat (3) @(negedge clk);
      finish_run();
   end

endmodule